// File: doc/BRIEF.md
# Quarter-Wave Sine Lookup

This block turns a phase word into a signed sine sample while holding only one quarter of the waveform in its table. The upper two phase bits pick the quadrant of the cycle. The lower bits address a quarter-wave magnitude table. In the falling quadrants that address is complemented, so the table is read backwards. In the second half of the cycle the magnitude is negated, so a single quarter reproduces the whole cycle without a step at any quadrant edge.

The table contents are computed during elaboration by a constant function and are never loaded from outside. Each entry samples the quarter wave half a phase step away from the grid points. Because of that offset, mirroring at a quadrant edge lands on a new point of the wave and never reuses a grid position.

Phase words enter on a valid/ready stream and samples leave on another. The two pipeline stages move only together. A word is accepted when `ph_valid` and `ph_ready` are both high at a rising edge. A sample is consumed when `smp_valid` and `smp_ready` are both high at a rising edge. While the consumer holds `smp_ready` low with a sample pending, the pipeline freezes, `ph_ready` drops, and the pending sample stays unchanged.

Top module: `qsin_lookup`

## Requirements
- R1: After reset `smp_valid` is low and `ph_ready` is high.
- R2: With `smp_ready` held high, a phase accepted at one rising edge appears as a valid sample after the second following rising edge (latency 2).
- R3: Quadrant 0 (phase bits [9:8] = 00): the sample equals T(k) with k = phase[7:0], where T(k) = round(127 * sin((2k+1)*pi/1024)) and round means adding one half and truncating.
- R4: Quadrant 1 (bits [9:8] = 01): the sample equals T(255 - k), the table walked backwards.
- R5: Quadrant 2 (bits [9:8] = 10): the sample equals -T(k) in 8-bit two's complement.
- R6: Quadrant 3 (bits [9:8] = 11): the sample equals -T(255 - k).
- R7: A valid sample is never 8'h80: every output lies from -127 to +127, with T(0) = 0 and T(255) = 127.
- R8: While `smp_valid` is high and `smp_ready` is low, the sample holds its value and stays valid. No accepted phase is lost or duplicated, and samples leave in the order the phases were accepted.
- R9: `ph_ready` is high exactly when `smp_valid` is low or `smp_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| ph_valid | input | 1 | Phase word present |
| ph_ready | output | 1 | Block can take a phase word this cycle |
| ph_word | input | 10 | Phase: [9:8] quadrant, [7:0] position within it |
| smp_valid | output | 1 | Sample present |
| smp_ready | input | 1 | Consumer takes the sample this cycle |
| smp_data | output | 8 | Signed two's-complement sine sample |

## Verification
If the ROM index or the quadrant flag is wrong in the first stage, the sample seen two edges later carries the wrong magnitude or the wrong sign. The bench compares every sample with a value computed separately from the sine formula, so such a fault shows up at the first affected sample. A fault in the stall logic shows up as a changed sample while `smp_ready` is low, or as a count or order mismatch between accepted phases and delivered samples by the time the stream drains. A sign fault at the zero crossings is exposed by directed phases at the quadrant edges, where an error would produce 8'h80 or a nonzero value.

// File: rtl/qsin_pkg.sv
package qsin_pkg;

  // Magnitude of a quarter-wave entry, sampled half a step off the grid.
  // Taylor series evaluated at elaboration; error is far below one LSB.
  function automatic int unsigned qsin_mag(input int unsigned k,
                                           input int unsigned depth,
                                           input int unsigned amp);
    real x;
    real term;
    real acc;
    x    = (2.0 * k + 1.0) * 3.14159265358979323846 / (4.0 * depth);
    term = x;
    acc  = x;
    for (int n = 1; n < 12; n++) begin
      term = -term * x * x / ((2.0 * n) * (2.0 * n + 1.0));
      acc  = acc + term;
    end
    return $rtoi(amp * acc + 0.5);
  endfunction

endpackage

// File: rtl/qsin_fold.sv
module qsin_fold #(
  parameter int PHASE_W = 10,
  localparam int IDX_W  = PHASE_W - 2
) (
  input  logic [PHASE_W-1:0] phase,
  output logic [IDX_W-1:0]   rom_idx,
  output logic               negate
);
  logic [1:0] quad;

  always_comb begin
    quad    = phase[PHASE_W-1 -: 2];
    // odd quadrants fall toward zero: walk the table backwards
    rom_idx = quad[0] ? ~phase[IDX_W-1:0] : phase[IDX_W-1:0];
    // second half of the cycle is below zero
    negate  = quad[1];
  end
endmodule

// File: rtl/qsin_rom.sv
module qsin_rom #(
  parameter int IDX_W = 8,
  parameter int MAG_W = 7,
  localparam int DEPTH = 1 << IDX_W,
  localparam int AMP   = (1 << MAG_W) - 1
) (
  input  logic             clk,
  input  logic             en,
  input  logic [IDX_W-1:0] idx,
  output logic [MAG_W-1:0] mag
);
  import qsin_pkg::*;

  logic [MAG_W-1:0] tbl [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_entry
    localparam int unsigned VAL = qsin_mag(k, DEPTH, AMP);
    assign tbl[k] = MAG_W'(VAL);
  end

  always_ff @(posedge clk) begin
    if (en) mag <= tbl[idx];
  end
endmodule

// File: rtl/qsin_sign.sv
module qsin_sign #(
  parameter int MAG_W = 7,
  localparam int OUT_W = MAG_W + 1
) (
  input  logic             clk,
  input  logic             en,
  input  logic [MAG_W-1:0] mag,
  input  logic             negate,
  output logic [OUT_W-1:0] sample
);
  logic [OUT_W-1:0] ext;

  always_comb ext = {1'b0, mag};

  always_ff @(posedge clk) begin
    if (en) sample <= negate ? (~ext + OUT_W'(1)) : ext;
  end
endmodule

// File: rtl/qsin_lookup.sv
module qsin_lookup #(
  parameter int PHASE_W = 10,
  parameter int OUT_W   = 8,
  localparam int IDX_W  = PHASE_W - 2,
  localparam int MAG_W  = OUT_W - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ph_valid,
  output logic               ph_ready,
  input  logic [PHASE_W-1:0] ph_word,
  output logic               smp_valid,
  input  logic               smp_ready,
  output logic [OUT_W-1:0]   smp_data
);
  logic             advance;
  logic [IDX_W-1:0] idx;
  logic             neg_d;
  logic             neg_q;
  logic             v1_q;
  logic             v2_q;
  logic [MAG_W-1:0] mag_q;

  // both stages shift together; a pending unconsumed sample freezes them
  always_comb advance = !v2_q || smp_ready;
  assign ph_ready = advance;

  qsin_fold #(.PHASE_W(PHASE_W)) u_fold (
    .phase   (ph_word),
    .rom_idx (idx),
    .negate  (neg_d)
  );

  qsin_rom #(.IDX_W(IDX_W), .MAG_W(MAG_W)) u_rom (
    .clk (clk),
    .en  (advance),
    .idx (idx),
    .mag (mag_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1_q  <= 1'b0;
      v2_q  <= 1'b0;
      neg_q <= 1'b0;
    end else if (advance) begin
      v1_q  <= ph_valid;
      v2_q  <= v1_q;
      neg_q <= neg_d;
    end
  end

  qsin_sign #(.MAG_W(MAG_W)) u_sign (
    .clk    (clk),
    .en     (advance),
    .mag    (mag_q),
    .negate (neg_q),
    .sample (smp_data)
  );

  assign smp_valid = v2_q;
endmodule

// File: rtl/qsin_lookup_chk.sv
module qsin_lookup_chk #(
  parameter int PHASE_W = 10,
  parameter int OUT_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ph_valid,
  input logic               ph_ready,
  input logic [PHASE_W-1:0] ph_word,
  input logic               smp_valid,
  input logic               smp_ready,
  input logic [OUT_W-1:0]   smp_data
);
  localparam logic [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};

  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && !smp_ready |=> smp_valid && $stable(smp_data));

  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ph_valid && ph_ready, 2) && $past(smp_ready) |-> smp_valid);

  a_r7_no_most_neg: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> smp_data != MOST_NEG);

  a_r5_neg_half: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ph_valid && ph_ready && ph_word[PHASE_W-1], 2) && $past(smp_ready)
    |-> smp_data[OUT_W-1] || smp_data == '0);

  a_r3_pos_half: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ph_valid && ph_ready && !ph_word[PHASE_W-1], 2) && $past(smp_ready)
    |-> !smp_data[OUT_W-1]);

  a_r9_ready_rule: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |-> ph_ready);
endmodule

bind qsin_lookup qsin_lookup_chk #(.PHASE_W(PHASE_W), .OUT_W(OUT_W)) u_chk (.*);

// File: tb/qsin_lookup_bench.sv
module qsin_lookup_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ph_valid = 1'b0;
  logic       ph_ready;
  logic [9:0] ph_word = '0;
  logic       smp_valid;
  logic       smp_ready = 1'b0;
  logic [7:0] smp_data;

  int checks = 0;
  int bad = 0;
  int cyc = 0;
  bit lat_mode = 0;
  logic [7:0] exp_q [$];
  int         acc_q [$];
  logic [9:0] ph_q  [$];
  bit         hold_armed = 0;
  logic [7:0] hold_val;
  int         delivered = 0;
  int         accepted = 0;

  always #2.5 clk = ~clk;

  qsin_lookup u_qsin_lookup (.*);

  function automatic logic [7:0] expect_smp(input logic [9:0] p);
    int k;
    int m;
    k = p[7:0];
    if (p[8]) k = 255 - k;
    m = $rtoi(127.0 * $sin((2.0 * k + 1.0) * 3.14159265358979323846 / 1024.0) + 0.5);
    return p[9] ? 8'(-m) : 8'(m);
  endfunction

  function automatic string req_of(input logic [9:0] p);
    case (p[9:8])
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // one cycle: drive at negedge, settle, score the handshakes that the next edge commits
  task automatic step(input bit v, input logic [9:0] p, input bit rdy);
    @(negedge clk);
    cyc++;
    // R8: a stalled sample must still be present and unchanged
    if (hold_armed) begin
      check(smp_valid == 1'b1, "R8 valid held", int'(smp_valid), 1);
      check(smp_data == hold_val, "R8 data held", int'(smp_data), int'(hold_val));
    end
    ph_valid  = v;
    ph_word   = p;
    smp_ready = rdy;
    #1;
    check(ph_ready == (!smp_valid || smp_ready), "R9", int'(ph_ready),
          int'(!smp_valid || smp_ready));
    if (smp_valid && smp_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 extra sample", 1, 0);
      end else begin
        logic [7:0] e;
        logic [9:0] pp;
        int a;
        e  = exp_q.pop_front();
        pp = ph_q.pop_front();
        a  = acc_q.pop_front();
        check(smp_data == e, req_of(pp), int'($signed(smp_data)), int'($signed(e)));
        check(smp_data != 8'h80, "R7", int'(smp_data), 0);
        if (lat_mode) check(cyc - a == 2, "R2", cyc - a, 2);
      end
      delivered++;
    end
    hold_armed = smp_valid && !smp_ready;
    hold_val   = smp_data;
    if (ph_valid && ph_ready) begin
      exp_q.push_back(expect_smp(p));
      ph_q.push_back(p);
      acc_q.push_back(cyc);
      accepted++;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    seed = 32'd12345;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(smp_valid == 1'b0, "R1 valid", int'(smp_valid), 0);
    check(ph_ready == 1'b1, "R1 ready", int'(ph_ready), 1);

    // directed edges and extremes, consumer always ready (R2..R7)
    lat_mode = 1;
    step(1, 10'd0,   1); step(1, 10'd255, 1); step(1, 10'd256, 1);
    step(1, 10'd511, 1); step(1, 10'd512, 1); step(1, 10'd767, 1);
    step(1, 10'd768, 1); step(1, 10'd1023, 1); step(1, 10'd128, 1);
    step(1, 10'd640, 1);
    for (int i = 0; i < 6; i++) step(0, '0, 1);
    // table end points (R7)
    check(expect_smp(10'd0) == 8'd0, "R7 T(0)", int'(expect_smp(10'd0)), 0);
    check(expect_smp(10'd255) == 8'd127, "R7 T(255)", int'(expect_smp(10'd255)), 127);

    // full sweep of every phase, ready high
    for (int p = 0; p < 1024; p++) step(1, 10'(p), 1);
    for (int i = 0; i < 4; i++) step(0, '0, 1);
    lat_mode = 0;

    // random traffic with back-pressure (R8)
    for (int i = 0; i < 4000; i++)
      step(($urandom % 4) != 0, 10'($urandom), ($urandom % 3) != 0);
    // long stall
    step(1, 10'd300, 1); step(1, 10'd900, 1);
    for (int i = 0; i < 8; i++) step(1, 10'd5, 0);
    for (int i = 0; i < 8; i++) step(0, '0, 1);

    check(exp_q.size() == 0, "R8 drained", exp_q.size(), 0);
    check(accepted == delivered, "R8 count", delivered, accepted);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule